// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a processor's byte-wide I/O bus and an asynchronous serial transmitter/receiver core. It decodes three ports selected by a two-bit port code: a control port that also reads back the modem input lines, a shared port that reads as the line status and is written as either the character format or the handshake outputs, and a data port that moves bytes to and from the core.

A load-enable flag, set or cleared by bit 1 of every control-port write, steers each write to the shared port. With the flag set, the write sets the character format: word length, stop bits and parity. With the flag clear, the write drives the RTS, DTR and break outputs instead. The format and handshake outputs are registers and change only when a write is accepted.

The data port carries no back-pressure. A data read pulses a one-cycle acknowledge that tells the core to clear its received-data flag. A data write pulses a one-cycle load strobe along with the byte, and the core must take it in that cycle. Software is expected to check the transmit-empty status flag before it writes. All read data is registered.

Top module: `sio_regfront`

## Requirements
- R1: After reset the format outputs show 8 data bits (`fmt_len_code` = 3), one stop bit, parity disabled and odd parity selected. The handshake outputs, `rx_ack`, `tx_load` and `cpu_rdata` are all 0, and the load-enable flag is clear.
- R2: Port codes are 0 = control, 1 = status/config, 2 = data. Bit 1 of each control-port write sets or clears the load-enable flag, and the flag keeps its value through writes to other ports until the control port is written again.
- R3: When load-enable is set, a config write takes bit 7 as even parity (1) or odd (0), bit 4 as two stop bits (1) or one (0), and bit 3 as parity disable (1).
- R4: When load-enable is set, bits 6 and 5 of a config write choose the word length: 11 gives 8 bits, 01 gives 7, 10 gives 6 and 00 gives 5. The result appears on `fmt_len_code` as length minus 5.
- R5: When load-enable is clear, a config write drives `hs_rts` from bit 0, `hs_dtr` from bit 1 and `hs_brk` from bit 2, and leaves the format outputs unchanged.
- R6: When load-enable is set, a config write leaves the handshake outputs unchanged.
- R7: A read of the status/config port returns, on the cycle after the read, data-received on bit 7, transmit-empty on bit 6, overrun on bit 5, framing error on bit 4 and parity error on bit 3, all active high. Bits 2 to 0 read 1.
- R8: A read of the control port returns CTS on bit 7, DSR on bit 6, carrier detect on bit 5, ring indicator on bit 4 and the received line level on bit 1, with bits 3, 2 and 0 reading 0.
- R9: A data-port read returns the core's received byte on `cpu_rdata` and raises `rx_ack` for exactly one cycle, both on the cycle after the read.
- R10: A data-port write raises `tx_load` for exactly one cycle on the next cycle, with the written byte on `tx_byte`. No other access raises `tx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_sel | input | 2 | Port code: 0 control, 1 status/config, 2 data |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| core_rx_byte | input | 8 | Received byte held by the core |
| core_rx_avail | input | 1 | Core has a received byte |
| core_tx_empty | input | 1 | Core transmit holding register is empty |
| core_overrun | input | 1 | Receive overrun flag |
| core_frame_err | input | 1 | Framing error flag |
| core_par_err | input | 1 | Parity error flag |
| mdm_cts | input | 1 | Clear-to-send input |
| mdm_dsr | input | 1 | Data-set-ready input |
| mdm_dcd | input | 1 | Carrier detect input |
| mdm_ri | input | 1 | Ring indicator input |
| mdm_rxd | input | 1 | Received line level |
| fmt_len_code | output | 2 | Word length minus 5 |
| fmt_two_stop | output | 1 | Two stop bits |
| fmt_par_off | output | 1 | Parity disabled |
| fmt_even_par | output | 1 | Even parity |
| hs_rts | output | 1 | RTS output |
| hs_dtr | output | 1 | DTR output |
| hs_brk | output | 1 | Break control output |
| rx_ack | output | 1 | One-cycle received-byte acknowledge |
| tx_load | output | 1 | One-cycle transmit load strobe |
| tx_byte | output | 8 | Byte that goes with tx_load |

## Verification
Every result of this block is a register loaded on the edge that samples the access. Read data, the format and handshake outputs, `rx_ack` and `tx_load` therefore all change one cycle after the strobe, and the two pulses drop one cycle after that. The bench drives each access at a falling edge and removes it at the next falling edge. It checks the outputs at that second falling edge, which lies just after the edge that registered them. For the pulses it checks once more a full cycle later to confirm they fell.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] PORT_CTL  = 2'd0;
  localparam logic [SEL_W-1:0] PORT_CFG  = 2'd1;
  localparam logic [SEL_W-1:0] PORT_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] len_code;
    logic       two_stop;
    logic       par_off;
    logic       even_par;
  } sio_fmt_t;

  localparam sio_fmt_t FMT_RESET = '{len_code: 2'd3, two_stop: 1'b0,
                                     par_off: 1'b1, even_par: 1'b0};
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_load_bit,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output sio_fmt_t   fmt,
  output logic       rts,
  output logic       dtr,
  output logic       brk
);
  logic load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en <= 1'b0;
    end else if (ctl_we) begin
      load_en <= ctl_load_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt <= FMT_RESET;
    end else if (cfg_we && load_en) begin
      fmt.len_code <= {cfg_wdata[5], cfg_wdata[6]};
      fmt.two_stop <= cfg_wdata[4];
      fmt.par_off  <= cfg_wdata[3];
      fmt.even_par <= cfg_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts <= 1'b0;
      dtr <= 1'b0;
      brk <= 1'b0;
    end else if (cfg_we && !load_en) begin
      rts <= cfg_wdata[0];
      dtr <= cfg_wdata[1];
      brk <= cfg_wdata[2];
    end
  end
endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic [SEL_W-1:0] sel,
  input  logic [7:0]       rx_byte,
  input  logic             rx_avail,
  input  logic             tx_empty,
  input  logic             overrun,
  input  logic             frame_err,
  input  logic             par_err,
  input  logic             cts,
  input  logic             dsr,
  input  logic             dcd,
  input  logic             ri,
  input  logic             rxd,
  output logic [7:0]       rdata
);
  logic [7:0] status_byte;
  logic [7:0] modem_byte;
  logic [7:0] next_byte;

  assign status_byte = {rx_avail, tx_empty, overrun, frame_err, par_err, 3'b111};
  assign modem_byte  = {cts, dsr, dcd, ri, 2'b00, rxd, 1'b0};

  always_comb begin
    unique case (sel)
      PORT_CTL:  next_byte = modem_byte;
      PORT_CFG:  next_byte = status_byte;
      PORT_DATA: next_byte = rx_byte;
      default:   next_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd) begin
      rdata <= next_byte;
    end
  end
endmodule

// File: rtl/sio_data_strobes.sv
module sio_data_strobes (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_hit,
  input  logic       wr_hit,
  input  logic [7:0] wdata,
  output logic       rx_ack,
  output logic       tx_load,
  output logic [7:0] tx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ack  <= 1'b0;
      tx_load <= 1'b0;
      tx_byte <= 8'h00;
    end else begin
      rx_ack  <= rd_hit;
      tx_load <= wr_hit;
      if (wr_hit) begin
        tx_byte <= wdata;
      end
    end
  end
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] cpu_sel,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic [7:0]       core_rx_byte,
  input  logic             core_rx_avail,
  input  logic             core_tx_empty,
  input  logic             core_overrun,
  input  logic             core_frame_err,
  input  logic             core_par_err,
  input  logic             mdm_cts,
  input  logic             mdm_dsr,
  input  logic             mdm_dcd,
  input  logic             mdm_ri,
  input  logic             mdm_rxd,
  output logic [1:0]       fmt_len_code,
  output logic             fmt_two_stop,
  output logic             fmt_par_off,
  output logic             fmt_even_par,
  output logic             hs_rts,
  output logic             hs_dtr,
  output logic             hs_brk,
  output logic             rx_ack,
  output logic             tx_load,
  output logic [7:0]       tx_byte
);
  sio_fmt_t fmt_q;
  logic     ctl_we;
  logic     cfg_we;
  logic     data_wr;
  logic     data_rd;

  assign ctl_we  = cpu_wr && (cpu_sel == PORT_CTL);
  assign cfg_we  = cpu_wr && (cpu_sel == PORT_CFG);
  assign data_wr = cpu_wr && (cpu_sel == PORT_DATA);
  assign data_rd = cpu_rd && (cpu_sel == PORT_DATA);

  sio_cfg_regs u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .ctl_load_bit (cpu_wdata[1]),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cpu_wdata),
    .fmt          (fmt_q),
    .rts          (hs_rts),
    .dtr          (hs_dtr),
    .brk          (hs_brk)
  );

  sio_read_mux u_rmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (cpu_rd),
    .sel       (cpu_sel),
    .rx_byte   (core_rx_byte),
    .rx_avail  (core_rx_avail),
    .tx_empty  (core_tx_empty),
    .overrun   (core_overrun),
    .frame_err (core_frame_err),
    .par_err   (core_par_err),
    .cts       (mdm_cts),
    .dsr       (mdm_dsr),
    .dcd       (mdm_dcd),
    .ri        (mdm_ri),
    .rxd       (mdm_rxd),
    .rdata     (cpu_rdata)
  );

  sio_data_strobes u_strb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hit  (data_rd),
    .wr_hit  (data_wr),
    .wdata   (cpu_wdata),
    .rx_ack  (rx_ack),
    .tx_load (tx_load),
    .tx_byte (tx_byte)
  );

  assign fmt_len_code = fmt_q.len_code;
  assign fmt_two_stop = fmt_q.two_stop;
  assign fmt_par_off  = fmt_q.par_off;
  assign fmt_even_par = fmt_q.even_par;
endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk
  import sio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] cpu_sel,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic [7:0]       cpu_wdata,
  input logic [7:0]       cpu_rdata,
  input logic [1:0]       fmt_len_code,
  input logic             fmt_two_stop,
  input logic             fmt_par_off,
  input logic             fmt_even_par,
  input logic             hs_rts,
  input logic             hs_dtr,
  input logic             hs_brk,
  input logic             rx_ack,
  input logic             tx_load,
  input logic [7:0]       tx_byte
);
  logic cfg_access;
  assign cfg_access = cpu_wr && (cpu_sel == PORT_CFG);

  // R3 R5: format and handshake outputs move only on a config write
  assert_cfg_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_access |=> $stable({fmt_len_code, fmt_two_stop, fmt_par_off, fmt_even_par,
                             hs_rts, hs_dtr, hs_brk}));

  // R7: low status bits read as ones
  assert_status_low_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_sel == PORT_CFG) |=> (cpu_rdata[2:0] == 3'b111));

  // R8: unused modem bits read as zero
  assert_modem_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_sel == PORT_CTL) |=> (cpu_rdata[3:2] == 2'b00 && cpu_rdata[0] == 1'b0));

  // R9: acknowledge follows a data read and nothing else
  assert_ack_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_sel == PORT_DATA) |=> rx_ack);
  assert_no_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_sel == PORT_DATA) |=> !rx_ack);

  // R10: load strobe carries the written byte
  assert_load_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel == PORT_DATA) |=> (tx_load && tx_byte == $past(cpu_wdata)));
  assert_no_stray_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_sel == PORT_DATA) |=> !tx_load);
endmodule

bind sio_regfront sio_regfront_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_sel      (cpu_sel),
  .cpu_wr       (cpu_wr),
  .cpu_rd       (cpu_rd),
  .cpu_wdata    (cpu_wdata),
  .cpu_rdata    (cpu_rdata),
  .fmt_len_code (fmt_len_code),
  .fmt_two_stop (fmt_two_stop),
  .fmt_par_off  (fmt_par_off),
  .fmt_even_par (fmt_even_par),
  .hs_rts       (hs_rts),
  .hs_dtr       (hs_dtr),
  .hs_brk       (hs_brk),
  .rx_ack       (rx_ack),
  .tx_load      (tx_load),
  .tx_byte      (tx_byte)
);

// File: tb/sio_regfront_tb.sv
module sio_regfront_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_sel = 2'd0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic [7:0] core_rx_byte = 8'h00;
  logic       core_rx_avail = 1'b0, core_tx_empty = 1'b0, core_overrun = 1'b0;
  logic       core_frame_err = 1'b0, core_par_err = 1'b0;
  logic       mdm_cts = 1'b0, mdm_dsr = 1'b0, mdm_dcd = 1'b0, mdm_ri = 1'b0, mdm_rxd = 1'b0;
  logic [1:0] fmt_len_code;
  logic       fmt_two_stop, fmt_par_off, fmt_even_par;
  logic       hs_rts, hs_dtr, hs_brk, rx_ack, tx_load;
  logic [7:0] tx_byte;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sio_regfront u_dut (.*);

  // {config write byte, expected {len_code, two_stop, par_off, even_par}}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {8'hE0, 5'b11001},
    {8'h30, 5'b10100},
    {8'h48, 5'b01010},
    {8'h9F, 5'b00111},
    {8'h07, 5'b00000},
    {8'hFF, 5'b11111}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] sel, input logic wr, input logic rd, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  function automatic logic [7:0] fmt_now();
    return {3'b000, fmt_len_code, fmt_two_stop, fmt_par_off, fmt_even_par};
  endfunction

  function automatic logic [7:0] hs_now();
    return {5'b00000, hs_brk, hs_dtr, hs_rts};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fmt", fmt_now(), 8'h1A);
    chk("R1 hs", hs_now(), 8'h00);
    chk("R1 strobes", {6'd0, rx_ack, tx_load}, 8'h00);
    chk("R1 rdata", cpu_rdata, 8'h00);
    // R1 load-enable clear: config write goes to handshake, format held
    bus(2'd1, 1'b1, 1'b0, 8'hE1);
    chk("R1 load-en clear hs", hs_now(), 8'h01);
    chk("R1 load-en clear fmt", fmt_now(), 8'h1A);

    // R2 set load-enable, then R3/R4 vector walk
    bus(2'd0, 1'b1, 1'b0, 8'h02);
    for (int i = 0; i < NV; i++) begin
      bus(2'd1, 1'b1, 1'b0, VEC[i][12:5]);
      chk($sformatf("R3 R4 vec%0d fmt", i), fmt_now(), {3'b000, VEC[i][4:0]});
      // R6 handshake held while load-enable set
      chk($sformatf("R6 vec%0d hs", i), hs_now(), 8'h01);
      // R2 other-port write keeps the flag
      bus(2'd2, 1'b1, 1'b0, 8'h00);
    end

    // R2 clearing load-enable: R5 handshake path
    bus(2'd0, 1'b1, 1'b0, 8'hFD);
    bus(2'd1, 1'b1, 1'b0, 8'h05);
    chk("R5 hs rts+brk", hs_now(), 8'h05);
    chk("R5 fmt held", fmt_now(), 8'h1F);
    bus(2'd1, 1'b1, 1'b0, 8'hE2);
    chk("R5 hs dtr", hs_now(), 8'h02);
    chk("R2 flag stays clear", fmt_now(), 8'h1F);

    // R7 status
    core_rx_avail = 1; core_tx_empty = 0; core_overrun = 1; core_frame_err = 0; core_par_err = 1;
    bus(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R7 status a", cpu_rdata, 8'hAF);
    core_rx_avail = 0; core_tx_empty = 1; core_overrun = 0; core_frame_err = 1; core_par_err = 0;
    bus(2'd1, 1'b0, 1'b1, 8'h00);
    chk("R7 status b", cpu_rdata, 8'h57);

    // R8 modem lines
    mdm_cts = 1; mdm_dsr = 0; mdm_dcd = 1; mdm_ri = 0; mdm_rxd = 1;
    bus(2'd0, 1'b0, 1'b1, 8'h00);
    chk("R8 modem a", cpu_rdata, 8'hA2);
    mdm_cts = 0; mdm_dsr = 1; mdm_dcd = 0; mdm_ri = 1; mdm_rxd = 0;
    bus(2'd0, 1'b0, 1'b1, 8'h00);
    chk("R8 modem b", cpu_rdata, 8'h50);

    // R9 data read
    core_rx_byte = 8'h3C;
    bus(2'd2, 1'b0, 1'b1, 8'h00);
    chk("R9 rdata", cpu_rdata, 8'h3C);
    chk("R9 ack high", {7'd0, rx_ack}, 8'h01);
    chk("R10 no load on read", {7'd0, tx_load}, 8'h00);
    @(negedge clk);
    chk("R9 ack one cycle", {7'd0, rx_ack}, 8'h00);

    // R10 data write
    bus(2'd2, 1'b1, 1'b0, 8'hC5);
    chk("R10 load high", {7'd0, tx_load}, 8'h01);
    chk("R10 byte", tx_byte, 8'hC5);
    chk("R9 no ack on write", {7'd0, rx_ack}, 8'h00);
    @(negedge clk);
    chk("R10 load one cycle", {7'd0, tx_load}, 8'h00);
    bus(2'd1, 1'b1, 1'b0, 8'h00);
    chk("R10 no load on config write", {7'd0, tx_load}, 8'h00);

    finish_run();
  end
endmodule